// File: doc/BRIEF.md
# List-Driven I/O Processor

This block lets a CPU hand off a whole I/O job with a single start pulse. The pulse carries an opcode, the index of a target device and the word address of a command list in main memory. From there the block works alone. It reads each command from memory and decodes it. It moves the requested number of words between the chosen device and a memory buffer, one word at a time. Then it steps to the next command. An end marker stops the list and the block raises a one-cycle interrupt. An unknown opcode also stops the list, raises the interrupt and leaves an error flag set.

One memory port carries both the command fetches and the data moves. It uses a request/acknowledge handshake: the request stays high until the acknowledge arrives. Read data is valid in the acknowledge cycle, and a write takes effect in that cycle. Each device has its own request and acknowledge lines and its own read-data lane. A shared direction line, write-data bus and sideband byte go to every device. The sideband byte repeats the command's auxiliary field.

Top module: `iop_cmd_engine`

## Requirements
- R1: After reset `busy`, `irq`, `err`, `mem_req` and every `dev_req` bit are 0. While `busy` is 0, neither memory nor any device is requested.
- R2: A start pulse taken while idle with `start_op` = 0x01 and a device index below NDEV makes the block read word `start_addr`, then word `start_addr`+1, before any other memory access. A pending memory request holds its address and direction until acknowledged.
- R3: Command word 0 holds opcode in bits [7:0], count in bits [23:8] and auxiliary byte in bits [31:24]. Word 1 bits [AW-1:0] give the buffer address. Opcode 0x01 performs count device reads (`dev_we` = 0). The i-th word read is written to memory at buffer+i.
- R4: Opcode 0x02 performs count memory reads from buffer+i. Each word is then written to the device with `dev_we` = 1, in order.
- R5: When a command completes, the next command is fetched from the list pointer plus 2.
- R6: Opcode 0x00 ends the list. `irq` is high for exactly one cycle with `err` = 0, and `busy` is 0 in the following cycle.
- R7: Any opcode other than 0x00, 0x01 or 0x02 ends the list without executing later commands. `err` is set to 1 and `irq` pulses in the cycle `err` rises. `err` holds until the next accepted start.
- R8: A data command with count 0 raises no device request and no buffer access; the list continues.
- R9: A start pulse while busy is ignored; the running list completes unchanged.
- R10: A start pulse with `start_op` other than 0x01, or with a device index of NDEV or more, makes no memory access. It pulses `irq` with `err` = 1.
- R11: At most one `dev_req` bit is high at any time, and only the bit of the device named at start. A pending device request holds until acknowledged.
- R12: During every device transfer, `dev_aux` equals the auxiliary byte (bits [31:24] of word 0) of the command being executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle start pulse from the CPU |
| start_op | input | 8 | Start opcode (0x01 = run list) |
| start_dev | input | DEV_W | Target device index |
| start_addr | input | AW | Word address of the command list |
| busy | output | 1 | A job is in progress |
| irq | output | 1 | One-cycle completion interrupt |
| err | output | 1 | Last job ended on an error |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| dev_req | output | NDEV | Per-device request |
| dev_we | output | 1 | Device transfer is a write to the device |
| dev_wdata | output | 32 | Data written to the device |
| dev_aux | output | 8 | Auxiliary byte of the current command |
| dev_ack | input | NDEV | Per-device acknowledge |
| dev_rdata | input | NDEV*32 | Per-device read data, lane d at bits [32d+31:32d] |

## Verification
The bench builds the block with AW = 10 and NDEV = 3. Three devices is not a power of two, so a start naming device 3 fits the index field but is out of range, and the rejection path of R10 can be exercised. A 1024-word memory lets buffer addresses and list pointers sit well apart. Word 1 is filled with random bits above bit 9, which shows that only the low AW bits form the buffer address.

// File: rtl/iop_pkg.sv
package iop_pkg;

   localparam int WORD_W = 32;
   localparam int CNT_W  = 16;

   localparam logic [7:0] START_RUN   = 8'h01;
   localparam logic [7:0] OPC_END     = 8'h00;
   localparam logic [7:0] OPC_DEV2MEM = 8'h01;
   localparam logic [7:0] OPC_MEM2DEV = 8'h02;

   typedef struct packed {
      logic [7:0]       aux;
      logic [CNT_W-1:0] count;
      logic [7:0]       opc;
   } cmd_word0_t;

   typedef enum logic [1:0] {
      KIND_END,
      KIND_IN,
      KIND_OUT,
      KIND_BAD
   } cmd_kind_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_FETCH0,
      ST_FETCH1,
      ST_DECODE,
      ST_DEV_RD,
      ST_MEM_WR,
      ST_MEM_RD,
      ST_DEV_WR,
      ST_DONE
   } iop_state_e;

endpackage

// File: rtl/iop_cmd_decode.sv
module iop_cmd_decode
   import iop_pkg::*;
(
   input  cmd_word0_t w0,
   output cmd_kind_e  kind,
   output logic       zero_cnt
);

   always_comb begin
      unique case (w0.opc)
         OPC_END:     kind = KIND_END;
         OPC_DEV2MEM: kind = KIND_IN;
         OPC_MEM2DEV: kind = KIND_OUT;
         default:     kind = KIND_BAD;
      endcase
   end

   assign zero_cnt = (w0.count == '0);

endmodule

// File: rtl/iop_dev_port.sv
module iop_dev_port
   import iop_pkg::*;
#(
   parameter int NDEV  = 4,
   parameter int DEV_W = 2
) (
   input  logic [DEV_W-1:0]       sel,
   input  logic                   req_en,
   input  logic [NDEV-1:0]        dev_ack,
   input  logic [NDEV*WORD_W-1:0] dev_rdata,
   output logic [NDEV-1:0]        dev_req,
   output logic                   ack_sel,
   output logic [WORD_W-1:0]      rdata_sel
);

   for (genvar i = 0; i < NDEV; i++) begin : g_req
      assign dev_req[i] = req_en && (sel == DEV_W'(i));
   end

   if (NDEV == 1) begin : g_single
      assign ack_sel   = dev_ack[0];
      assign rdata_sel = dev_rdata[WORD_W-1:0];
   end else begin : g_multi
      always_comb begin
         ack_sel   = 1'b0;
         rdata_sel = '0;
         for (int i = 0; i < NDEV; i++) begin
            if (sel == DEV_W'(i)) begin
               ack_sel   = dev_ack[i];
               rdata_sel = dev_rdata[i*WORD_W +: WORD_W];
            end
         end
      end
   end

endmodule

// File: rtl/iop_seq.sv
module iop_seq
   import iop_pkg::*;
#(
   parameter int AW    = 16,
   parameter int NDEV  = 4,
   parameter int DEV_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [7:0]        start_op,
   input  logic [DEV_W-1:0]  start_dev,
   input  logic [AW-1:0]     start_addr,
   input  cmd_kind_e         kind,
   input  logic              zero_cnt,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              dev_ack_sel,
   input  logic [WORD_W-1:0] dev_rdata_sel,
   output cmd_word0_t        cmd_w0,
   output logic [DEV_W-1:0]  dev_sel,
   output logic              dev_req_en,
   output logic              dev_we,
   output logic [WORD_W-1:0] dev_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              busy,
   output logic              irq,
   output logic              err
);

   localparam logic [AW-1:0] STEP = AW'(2);

   iop_state_e        st;
   logic [AW-1:0]     ptr;
   logic [AW-1:0]     bufp;
   logic [CNT_W-1:0]  rem;
   logic [WORD_W-1:0] dreg;
   logic              err_q;
   logic              start_ok;
   logic              last_word;

   assign start_ok  = (start_op == START_RUN) && (int'(start_dev) < NDEV);
   assign last_word = (rem == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         st      <= ST_IDLE;
         ptr     <= '0;
         bufp    <= '0;
         rem     <= '0;
         dreg    <= '0;
         err_q   <= 1'b0;
         cmd_w0  <= '0;
         dev_sel <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  ptr     <= start_addr;
                  dev_sel <= start_dev;
                  if (start_ok) begin
                     err_q <= 1'b0;
                     st    <= ST_FETCH0;
                  end else begin
                     err_q <= 1'b1;
                     st    <= ST_DONE;
                  end
               end
            end
            ST_FETCH0: begin
               if (mem_ack) begin
                  cmd_w0 <= cmd_word0_t'(mem_rdata);
                  st     <= ST_FETCH1;
               end
            end
            ST_FETCH1: begin
               if (mem_ack) begin
                  bufp <= mem_rdata[AW-1:0];
                  st   <= ST_DECODE;
               end
            end
            ST_DECODE: begin
               unique case (kind)
                  KIND_END: st <= ST_DONE;
                  KIND_BAD: begin
                     err_q <= 1'b1;
                     st    <= ST_DONE;
                  end
                  default: begin
                     if (zero_cnt) begin
                        ptr <= ptr + STEP;
                        st  <= ST_FETCH0;
                     end else begin
                        rem <= cmd_w0.count;
                        st  <= (kind == KIND_IN) ? ST_DEV_RD : ST_MEM_RD;
                     end
                  end
               endcase
            end
            ST_DEV_RD: begin
               if (dev_ack_sel) begin
                  dreg <= dev_rdata_sel;
                  st   <= ST_MEM_WR;
               end
            end
            ST_MEM_WR: begin
               if (mem_ack) begin
                  bufp <= bufp + AW'(1);
                  rem  <= rem - CNT_W'(1);
                  if (last_word) begin
                     ptr <= ptr + STEP;
                     st  <= ST_FETCH0;
                  end else begin
                     st  <= ST_DEV_RD;
                  end
               end
            end
            ST_MEM_RD: begin
               if (mem_ack) begin
                  dreg <= mem_rdata;
                  st   <= ST_DEV_WR;
               end
            end
            ST_DEV_WR: begin
               if (dev_ack_sel) begin
                  bufp <= bufp + AW'(1);
                  rem  <= rem - CNT_W'(1);
                  if (last_word) begin
                     ptr <= ptr + STEP;
                     st  <= ST_FETCH0;
                  end else begin
                     st  <= ST_MEM_RD;
                  end
               end
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = ptr;
      unique case (st)
         ST_FETCH0: mem_req = 1'b1;
         ST_FETCH1: begin
            mem_req  = 1'b1;
            mem_addr = ptr + AW'(1);
         end
         ST_MEM_WR: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = bufp;
         end
         ST_MEM_RD: begin
            mem_req  = 1'b1;
            mem_addr = bufp;
         end
         default: ;
      endcase
   end

   assign mem_wdata  = dreg;
   assign dev_wdata  = dreg;
   assign dev_req_en = (st == ST_DEV_RD) || (st == ST_DEV_WR);
   assign dev_we     = (st == ST_DEV_WR);
   assign busy       = (st != ST_IDLE);
   assign irq        = (st == ST_DONE);
   assign err        = err_q;

endmodule

// File: rtl/iop_cmd_engine.sv
module iop_cmd_engine
   import iop_pkg::*;
#(
   parameter  int AW    = 16,
   parameter  int NDEV  = 4,
   localparam int DEV_W = (NDEV > 1) ? $clog2(NDEV) : 1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   start,
   input  logic [7:0]             start_op,
   input  logic [DEV_W-1:0]       start_dev,
   input  logic [AW-1:0]          start_addr,
   output logic                   busy,
   output logic                   irq,
   output logic                   err,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [AW-1:0]          mem_addr,
   output logic [WORD_W-1:0]      mem_wdata,
   input  logic                   mem_ack,
   input  logic [WORD_W-1:0]      mem_rdata,
   output logic [NDEV-1:0]        dev_req,
   output logic                   dev_we,
   output logic [WORD_W-1:0]      dev_wdata,
   output logic [7:0]             dev_aux,
   input  logic [NDEV-1:0]        dev_ack,
   input  logic [NDEV*WORD_W-1:0] dev_rdata
);

   if (AW < 2 || AW > WORD_W) begin : g_bad_aw
      $error("iop_cmd_engine: AW must lie in 2..32");
   end
   if (NDEV < 1 || NDEV > 256) begin : g_bad_ndev
      $error("iop_cmd_engine: NDEV must lie in 1..256");
   end

   cmd_word0_t        cmd_w0;
   cmd_kind_e         kind;
   logic              zero_cnt;
   logic [DEV_W-1:0]  dev_sel;
   logic              dev_req_en;
   logic              dev_ack_sel;
   logic [WORD_W-1:0] dev_rdata_sel;

   iop_cmd_decode u_dec (
      .w0       (cmd_w0),
      .kind     (kind),
      .zero_cnt (zero_cnt)
   );

   iop_dev_port #(.NDEV(NDEV), .DEV_W(DEV_W)) u_dev (
      .sel       (dev_sel),
      .req_en    (dev_req_en),
      .dev_ack   (dev_ack),
      .dev_rdata (dev_rdata),
      .dev_req   (dev_req),
      .ack_sel   (dev_ack_sel),
      .rdata_sel (dev_rdata_sel)
   );

   iop_seq #(.AW(AW), .NDEV(NDEV), .DEV_W(DEV_W)) u_seq (
      .clk           (clk),
      .rst           (rst),
      .start         (start),
      .start_op      (start_op),
      .start_dev     (start_dev),
      .start_addr    (start_addr),
      .kind          (kind),
      .zero_cnt      (zero_cnt),
      .mem_ack       (mem_ack),
      .mem_rdata     (mem_rdata),
      .dev_ack_sel   (dev_ack_sel),
      .dev_rdata_sel (dev_rdata_sel),
      .cmd_w0        (cmd_w0),
      .dev_sel       (dev_sel),
      .dev_req_en    (dev_req_en),
      .dev_we        (dev_we),
      .dev_wdata     (dev_wdata),
      .mem_req       (mem_req),
      .mem_we        (mem_we),
      .mem_addr      (mem_addr),
      .mem_wdata     (mem_wdata),
      .busy          (busy),
      .irq           (irq),
      .err           (err)
   );

   assign dev_aux = cmd_w0.aux;

endmodule

// File: rtl/iop_cmd_engine_chk.sv
module iop_cmd_engine_chk #(
   parameter int AW   = 16,
   parameter int NDEV = 4
) (
   input logic            clk,
   input logic            rst,
   input logic            start,
   input logic            busy,
   input logic            irq,
   input logic            err,
   input logic            mem_req,
   input logic            mem_we,
   input logic [AW-1:0]   mem_addr,
   input logic            mem_ack,
   input logic [NDEV-1:0] dev_req,
   input logic [NDEV-1:0] dev_ack
);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (!mem_req && (dev_req == '0)));

   // R2
   mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R11
   dev_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(dev_req));

   // R11
   dev_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (|(dev_req & ~dev_ack)) |=> $stable(dev_req));

   // R6
   irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      irq |=> (!irq && !busy));

   // R7
   err_irq_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(err) |-> irq);

   // R9
   busy_start_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !irq && start) |=> busy);

endmodule

bind iop_cmd_engine iop_cmd_engine_chk #(.AW(AW), .NDEV(NDEV)) u_chk (.*);

// File: tb/iop_cmd_engine_test.sv
module iop_cmd_engine_test;

   localparam int AW    = 10;
   localparam int NDEV  = 3;
   localparam int DEV_W = 2;
   localparam int MEMW  = 1 << AW;
   localparam int LOGN  = 2048;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst = 1'b1;
   logic              start = 1'b0;
   logic [7:0]        start_op = '0;
   logic [DEV_W-1:0]  start_dev = '0;
   logic [AW-1:0]     start_addr = '0;
   logic              busy, irq, err, mem_req, mem_we, dev_we;
   logic [AW-1:0]     mem_addr;
   logic [31:0]       mem_wdata, dev_wdata;
   logic              mem_ack = 1'b0;
   logic [31:0]       mem_rdata = '0;
   logic [NDEV-1:0]   dev_req;
   logic [7:0]        dev_aux;
   logic [NDEV-1:0]   dev_ack = '0;
   logic [NDEV*32-1:0] dev_rdata;

   iop_cmd_engine #(.AW(AW), .NDEV(NDEV)) uut (.*);

   // bench memory and device models
   logic [31:0] mem [MEMW];
   logic [AW:0] mlog [4096];
   int          mn = 0;
   int          mwait = 0;
   int          mreq_cycles = 0;
   int          dreq_cycles = 0;
   logic [40:0] dlog [NDEV][LOGN];
   int          dn [NDEV];
   int          dwait [NDEV];
   logic [23:0] rdseq [NDEV];
   logic [31:0] drd [NDEV];

   initial begin
      for (int d = 0; d < NDEV; d++) begin
         dn[d] = 0; dwait[d] = 0; rdseq[d] = '0; drd[d] = '0;
      end
   end

   always_comb begin
      for (int d = 0; d < NDEV; d++) dev_rdata[d*32 +: 32] = drd[d];
   end

   always @(posedge clk) begin
      if (mem_req) mreq_cycles <= mreq_cycles + 1;
      if (|dev_req) dreq_cycles <= dreq_cycles + 1;
      if (rst) begin
         mem_ack <= 1'b0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (mem_req) begin
         if (mwait == 0) begin
            mem_ack <= 1'b1;
            mwait   <= int'($urandom % 3);
            mlog[mn % 4096] <= {mem_we, mem_addr};
            mn <= mn + 1;
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata     <= mem[mem_addr];
         end else begin
            mwait <= mwait - 1;
         end
      end
   end

   always @(posedge clk) begin
      for (int d = 0; d < NDEV; d++) begin
         if (rst) begin
            dev_ack[d] <= 1'b0;
         end else if (dev_ack[d]) begin
            dev_ack[d] <= 1'b0;
         end else if (dev_req[d]) begin
            if (dwait[d] == 0) begin
               dev_ack[d] <= 1'b1;
               dwait[d]   <= int'($urandom % 4);
               if (dev_we) begin
                  dlog[d][dn[d] % LOGN] <= {1'b1, dev_wdata, dev_aux};
               end else begin
                  dlog[d][dn[d] % LOGN] <= {1'b0, 8'(d), rdseq[d], dev_aux};
                  drd[d]   <= {8'(d), rdseq[d]};
                  rdseq[d] <= rdseq[d] + 24'd1;
               end
               dn[d] <= dn[d] + 1;
            end else begin
               dwait[d] <= dwait[d] - 1;
            end
         end
      end
   end

   // bookkeeping of the bench
   int nchk = 0;
   int nfail = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // expectations computed from the requirements
   logic [40:0] explog [64];
   int          expn;
   logic [AW-1:0] expma [64];
   logic [31:0] expmv [64];
   int          expm_n;
   int          bcur = 512;

   // word0 = {aux[31:24], count[23:8], opcode[7:0]}; word1[AW-1:0] = buffer (R3)
   task automatic build(input int base, input int ncmd, input int dv,
                        input logic [7:0] term_op, input bit zero_only);
      logic [23:0] seq;
      seq = rdseq[dv];
      expn = 0;
      expm_n = 0;
      if (bcur > 990) bcur = 512;
      for (int c = 0; c < ncmd; c++) begin
         logic [7:0]  opc;
         logic [7:0]  aux;
         int          cnt;
         int          bufa;
         opc  = ($urandom % 2 == 0) ? 8'h01 : 8'h02;
         aux  = 8'($urandom);
         cnt  = zero_only ? 0 : (($urandom % 4 == 0) ? 0 : 1 + int'($urandom % 4));
         bufa = bcur;
         bcur = bcur + cnt;
         mem[AW'(base + 2*c)]     <= {aux, 16'(cnt), opc};
         mem[AW'(base + 2*c + 1)] <= {22'($urandom), AW'(bufa)};
         for (int i = 0; i < cnt; i++) begin
            if (opc == 8'h02) begin
               logic [31:0] v;
               v = $urandom;
               mem[AW'(bufa + i)] <= v;
               explog[expn] = {1'b1, v, aux};
               expn++;
            end else begin
               explog[expn]  = {1'b0, 8'(dv), seq, aux};
               expma[expm_n] = AW'(bufa + i);
               expmv[expm_n] = {8'(dv), seq};
               expn++;
               expm_n++;
               seq = seq + 24'd1;
               mem[AW'(bufa + i)] <= 32'hDEAD_0000 | 32'(i);
            end
         end
      end
      mem[AW'(base + 2*ncmd)]     <= {8'($urandom), 16'($urandom), term_op};
      mem[AW'(base + 2*ncmd + 1)] <= $urandom;
      mem[AW'(base + 2*ncmd + 2)] <= {8'h55, 16'd3, 8'h01};
      mem[AW'(base + 2*ncmd + 3)] <= 32'(bcur);
      @(negedge clk);
   endtask

   task automatic run(input int base, input int dv, input logic [7:0] op,
                      input bit exp_err, input bit exp_fetch, input bit inject, input bit zero_only);
      int  mn0, dn0, mr0, dr0, others0, others1;
      bit  got;
      mn0 = mn; dn0 = (dv < NDEV) ? dn[dv] : 0; mr0 = mreq_cycles; dr0 = dreq_cycles;
      others0 = 0;
      for (int d = 0; d < NDEV; d++) if (d != dv) others0 += dn[d];
      @(negedge clk);
      start = 1'b1; start_op = op; start_dev = DEV_W'(dv); start_addr = AW'(base);
      @(negedge clk);
      start = 1'b0;
      got = 0;
      for (int t = 0; t < 20000 && !got; t++) begin
         if (irq) begin
            got = 1;
            start = 1'b0;
         end else begin
            start = inject && (t == 4);
            if (inject) start_addr = AW'(base + 300);
            @(negedge clk);
         end
      end
      start = 1'b0;
      chk(got, "R6 watchdog waiting for irq", 64'(got), 64'd1);
      chk(err == exp_err, exp_err ? "R7/R10 err set" : "R6 err clear", 64'(err), 64'(exp_err));
      @(negedge clk);
      chk(!busy && !irq, "R6 single irq pulse then idle", {busy, irq}, 64'd0);
      if (!exp_fetch) begin
         chk(mreq_cycles == mr0, "R10 no memory access", 64'(mreq_cycles - mr0), 64'd0);
         return;
      end
      chk(mlog[mn0 % 4096] == {1'b0, AW'(base)}, "R2 first fetch", 64'(mlog[mn0 % 4096]), 64'({1'b0, AW'(base)}));
      chk(mlog[(mn0 + 1) % 4096] == {1'b0, AW'(base + 1)}, "R2 second fetch",
          64'(mlog[(mn0 + 1) % 4096]), 64'({1'b0, AW'(base + 1)}));
      chk(dn[dv] - dn0 == expn, "R3/R4/R5/R7 transfer count", 64'(dn[dv] - dn0), 64'(expn));
      for (int k = 0; k < expn && k < dn[dv] - dn0; k++) begin
         logic [40:0] a;
         a = dlog[dv][(dn0 + k) % LOGN];
         chk(a[40:8] == explog[k][40:8], explog[k][40] ? "R4 device write data" : "R3 device read order",
             64'(a[40:8]), 64'(explog[k][40:8]));
         chk(a[7:0] == explog[k][7:0], "R12 aux byte", 64'(a[7:0]), 64'(explog[k][7:0]));
      end
      for (int k = 0; k < expm_n; k++) begin
         chk(mem[expma[k]] == expmv[k], "R3 buffer contents", 64'(mem[expma[k]]), 64'(expmv[k]));
      end
      others1 = 0;
      for (int d = 0; d < NDEV; d++) if (d != dv) others1 += dn[d];
      chk(others1 == others0, "R11 other devices untouched", 64'(others1 - others0), 64'd0);
      if (zero_only)
         chk(dreq_cycles == dr0, "R8 zero count never requests device", 64'(dreq_cycles - dr0), 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nchk++;
         nfail++;
         $display("FAIL global watchdog actual=%0d expected=%0d", 200000, 0);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < MEMW; i++) mem[i] <= '0;
      repeat (4) @(negedge clk);
      chk(!busy && !irq && !err && !mem_req && dev_req == '0, "R1 state during reset",
          {busy, irq, err, mem_req, 1'b0}, 64'd0);
      rst = 1'b0;
      @(negedge clk);
      chk(!busy && !irq && !err && !mem_req && dev_req == '0, "R1 state after reset",
          {busy, irq, err, mem_req, 1'b0}, 64'd0);

      // directed: plain list on device 0
      build(16, 3, 0, 8'h00, 0);
      run(16, 0, 8'h01, 0, 1, 0, 0);
      // R8: counts of zero only
      build(48, 3, 1, 8'h00, 1);
      run(48, 1, 8'h01, 0, 1, 0, 1);
      // R7: bad opcode stops the list, following valid command skipped
      build(80, 2, 2, 8'h7F, 0);
      run(80, 2, 8'h01, 1, 1, 0, 0);
      // R10: bad start opcode, then device index out of range
      run(16, 0, 8'h05, 1, 0, 0, 0);
      run(16, 3, 8'h01, 1, 0, 0, 0);
      // R9: second start during a busy list
      build(112, 4, 1, 8'h00, 0);
      mem[AW'(112)] <= {8'hA5, 16'd4, 8'h01};
      mem[AW'(113)] <= 32'(bcur);
      @(negedge clk);
      build(112, 4, 1, 8'h00, 0);
      run(112, 1, 8'h01, 0, 1, 1, 0);

      // random lists
      for (int r = 0; r < 20; r++) begin
         int base, ncmd, dv;
         logic [7:0] term;
         base = 160 + r * 16;
         ncmd = 1 + int'($urandom % 5);
         dv   = int'($urandom % NDEV);
         term = ($urandom % 4 == 0) ? (8'h80 | 8'($urandom)) : 8'h00;
         build(base, ncmd, dv, term, 0);
         run(base, dv, 8'h01, term != 8'h00, 1, 0, 0);
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule